// File: doc/BRIEF.md
# Amplifier Control and Diagnostic Status Serial Slave

This block is a two-wire (I2C) slave. It sets up a four-channel audio power amplifier and reports that amplifier's speaker diagnostics to a host. SCL and SDA are oversampled on the system clock. The block finds START and STOP conditions and tracks a single transfer at a time. Only one 7-bit address is answered.

A write transfer carries two instruction bytes. These set the block's control outputs: diagnostic enable, offset-detect enable, the front and rear gain selects, the front and rear unmute, the clip threshold, fast mute, amplifier-on (standby release) and line-driver thresholds. A read transfer returns four status bytes. Each byte carries one channel's fault nibble plus a few header bits, and some of those header bits echo control settings. When a read transfer ends with STOP, a one-cycle strobe goes out. The external diagnostic engine uses this strobe to start its next measurement cycle.

Top module: `amp_ctl_i2c_slave`

## Requirements
- R1: The address byte 1101100 followed by the R/W bit (D8h write, D9h read) is acknowledged by driving SDA low during the ninth clock. Any other address is not acknowledged, and nothing is changed until the next START.
- R2: A START (SDA falls while SCL is high) restarts the address phase from any state, so a partial byte is dropped. A STOP (SDA rises while SCL is high) returns the slave to idle.
- R3: First written byte: bit 6 goes to diag_en, bit 5 to offs_en, bit 4 to gain_front_lo and bit 3 to gain_rear_lo (1 = 16 dB). Bit 2 goes to unmute_front and bit 1 to unmute_rear (1 = unmuted). Bit 0 goes to clip_hi (1 = 10 %). Bit 7 is ignored.
- R4: Second written byte: bit 5 goes to fast_mute, bit 4 to amp_on (1 = out of standby) and bit 3 to line_mode. Bits 7, 6, 2, 1 and 0 are ignored.
- R5: Written bytes after the second are acknowledged and change no output.
- R6: Status bytes 1 to 4 carry channels LF, LR, RF and RR, taken from ch_flags[3:0], [7:4], [11:8] and [15:12]. In each byte, bit 3 is short load, bit 2 output offset, bit 1 short to supply and bit 0 short to ground. Every byte is sent MSB first.
- R7: Byte 1 bit 7 is thermal_warn and bit 6 is cycle_done. Byte 2 bit 7 is offset_active. Byte 3 bit 7 is amp_on and bit 6 is diag_en. All other bits in bits 7 to 4 read 0.
- R8: The slave keeps sending while the master acknowledges. Bytes after the fourth read 00h. After a NACK, SDA stays released until the next START or STOP.
- R9: read_done pulses for exactly one clock after a STOP that closes a transfer whose read address was acknowledged. Write-only transfers never pulse it.
- R10: Reset leaves every control output at 0 (standby, muted, 30 dB, 2 % clip) and SDA released.
- R11: The slave starts driving SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| ch_flags | input | 16 | Fault nibbles, LF in [3:0] up to RR in [15:12] |
| thermal_warn | input | 1 | Thermal warning flag |
| cycle_done | input | 1 | Diagnostic cycle finished |
| offset_active | input | 1 | Offset measurement running |
| diag_en | output | 1 | Diagnostic enable |
| offs_en | output | 1 | Offset-detect enable |
| gain_front_lo | output | 1 | Front gain 16 dB |
| gain_rear_lo | output | 1 | Rear gain 16 dB |
| unmute_front | output | 1 | Front channels play |
| unmute_rear | output | 1 | Rear channels play |
| clip_hi | output | 1 | Clip threshold 10 % |
| fast_mute | output | 1 | Short muting time |
| amp_on | output | 1 | Amplifier out of standby |
| line_mode | output | 1 | Line-driver diagnostic thresholds |
| read_done | output | 1 | One-cycle pulse, read transfer closed |

## Verification
Any bus edge takes three clocks to reach the protocol logic: two synchronizer stages and one edge register. The acknowledge and read-data drive therefore change about four clocks after the SCL falling edge that precedes them. The control outputs settle about five clocks after the falling edge of the eighth bit of each instruction byte. read_done rises about four clocks after the SDA rise of a STOP. The bench holds each SCL phase for eight clocks and samples SDA in the middle of the high phase. It checks the control outputs and read_done only after the STOP and a further idle quarter-period, well past every one of these latencies.

// File: rtl/amp_i2c_pkg.sv
// Package: shared constants and link state type for the amplifier control slave.
// Assumes four channels with a four-bit fault nibble each.
package amp_i2c_pkg;
    localparam int NUM_CH    = 4;
    localparam int NIB_W     = 4;
    localparam int FLAG_W    = NUM_CH * NIB_W;
    localparam int NUM_WR    = 2;   // instruction bytes honoured
    localparam int RD_IDX_W  = 3;   // counts status bytes, saturates at NUM_CH

    typedef enum logic [2:0] {
        L_IDLE, L_ADDR, L_AACK, L_WBYTE, L_WACK, L_RBYTE, L_RACK, L_SKIP
    } link_st_t;
endpackage

// File: rtl/amp_i2c_sampler.sv
// Line sampler: synchronises SCL/SDA to clk and flags SCL edges, START and STOP.
// Assumes bus edges are several clk periods apart.
module amp_i2c_sampler #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC-1:0] scl_sy, sda_sy;
    logic            scl_q, sda_q;

    // Synchronise both lines and keep the previous synchronised value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sy <= '1;
            sda_sy <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[SYNC-2:0], scl_i};
            sda_sy <= {sda_sy[SYNC-2:0], sda_i};
            scl_q  <= scl_sy[SYNC-1];
            sda_q  <= sda_sy[SYNC-1];
        end
    end

    // Edge and condition decode from current and previous samples.
    always_comb begin
        scl_lvl   = scl_sy[SYNC-1];
        sda_lvl   = sda_sy[SYNC-1];
        scl_rise  = scl_lvl & ~scl_q;
        scl_fall  = ~scl_lvl & scl_q;
        start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
        stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    end
endmodule

// File: rtl/amp_i2c_status.sv
// Status assembler: builds the status byte for a given read index from fault
// nibbles, header flags and echoed control bits. Indexes past the last read 0.
module amp_i2c_status
    import amp_i2c_pkg::*;
(
    input  logic [RD_IDX_W-1:0] idx,
    input  logic [FLAG_W-1:0]   ch_flags,
    input  logic                thermal_warn,
    input  logic                cycle_done,
    input  logic                offset_active,
    input  logic                amp_on,
    input  logic                diag_en,
    output logic [7:0]          byte_o
);
    logic [3:0] hdr [NUM_CH];
    logic [7:0] per_ch [NUM_CH];

    // Header nibble per byte position.
    always_comb begin
        hdr[0] = {thermal_warn, cycle_done, 2'b00};
        hdr[1] = {offset_active, 3'b000};
        hdr[2] = {amp_on, diag_en, 2'b00};
        hdr[3] = 4'b0000;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign per_ch[c] = {hdr[c], ch_flags[c*NIB_W +: NIB_W]};
    end

    // Select the byte for the current index; beyond the last channel reads zero.
    always_comb begin
        byte_o = 8'h00;
        for (int c = 0; c < NUM_CH; c++)
            if (idx == RD_IDX_W'(c)) byte_o = per_ch[c];
    end
endmodule

// File: rtl/amp_i2c_link.sv
// Link controller: bit/byte sequencing of the slave, address match, ACK drive,
// write byte strobes and read byte shifting. Assumes no clock stretching.
module amp_i2c_link
    import amp_i2c_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h6C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_lvl,
    input  logic                sda_lvl,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic [7:0]          rd_byte,
    output logic [RD_IDX_W-1:0] rd_idx,
    output logic                wr_stb,
    output logic [1:0]          wr_idx,
    output logic [7:0]          wr_data,
    output logic                sda_oe,
    output logic                read_done
);
    localparam logic [RD_IDX_W-1:0] RD_MAX = RD_IDX_W'(NUM_CH);

    link_st_t   st;
    logic [3:0] cnt;
    logic [7:0] sh, tx;
    logic       rw, rd_act, m_ack;

    assign wr_data = sh;

    // Protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= L_IDLE; cnt <= '0; sh <= '0; tx <= '0; rw <= 1'b0;
            sda_oe <= 1'b0; rd_act <= 1'b0; read_done <= 1'b0; m_ack <= 1'b0;
            wr_stb <= 1'b0; wr_idx <= '0; rd_idx <= '0;
        end else begin
            read_done <= 1'b0;
            wr_stb    <= 1'b0;
            if (start_det) begin
                st <= L_ADDR; cnt <= '0; sda_oe <= 1'b0;
                wr_idx <= '0; rd_idx <= '0;
            end else if (stop_det) begin
                st <= L_IDLE; sda_oe <= 1'b0;
                read_done <= rd_act; rd_act <= 1'b0;
            end else begin
                case (st)
                    L_ADDR: begin
                        if (scl_rise) begin
                            sh <= {sh[6:0], sda_lvl}; cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (sh[7:1] == ADDR7) begin
                                st <= L_AACK; sda_oe <= 1'b1; rw <= sh[0];
                            end else begin
                                st <= L_SKIP;
                            end
                        end
                    end
                    L_AACK: if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            st <= L_RBYTE; rd_act <= 1'b1;
                            tx <= rd_byte; sda_oe <= ~rd_byte[7];
                            rd_idx <= rd_idx + 1'b1;
                        end else begin
                            st <= L_WBYTE; sda_oe <= 1'b0;
                        end
                    end
                    L_WBYTE: begin
                        if (scl_rise) begin
                            sh <= {sh[6:0], sda_lvl}; cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            st <= L_WACK; sda_oe <= 1'b1; wr_stb <= 1'b1;
                        end
                    end
                    L_WACK: if (scl_fall) begin
                        st <= L_WBYTE; sda_oe <= 1'b0; cnt <= '0;
                        if (wr_idx != 2'(NUM_WR)) wr_idx <= wr_idx + 2'd1;
                    end
                    L_RBYTE: if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            st <= L_RACK; sda_oe <= 1'b0;
                        end else begin
                            tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
                            cnt <= cnt + 4'd1;
                        end
                    end
                    L_RACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (m_ack) begin
                                st <= L_RBYTE; cnt <= '0;
                                tx <= rd_byte; sda_oe <= ~rd_byte[7];
                                if (rd_idx != RD_MAX) rd_idx <= rd_idx + 1'b1;
                            end else begin
                                st <= L_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: the slave starts pulling SDA only while SCL is low.
    assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);
    // R9: the read strobe follows a detected STOP.
    assert_done_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        read_done |-> $past(stop_det));
    // R9: the read strobe lasts one cycle.
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        read_done |=> !read_done);
    // R2: bit counter never runs past a full byte.
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= 4'd8);
endmodule

// File: rtl/amp_ctl_i2c_slave.sv
// Top: two-wire slave for a four-channel amplifier. Holds the instruction
// registers and wires sampler, link controller and status assembler.
// Assumes clk is at least 16x faster than SCL.
module amp_ctl_i2c_slave
    import amp_i2c_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h6C,
    parameter int         SYNC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [FLAG_W-1:0] ch_flags,
    input  logic              thermal_warn,
    input  logic              cycle_done,
    input  logic              offset_active,
    output logic              diag_en,
    output logic              offs_en,
    output logic              gain_front_lo,
    output logic              gain_rear_lo,
    output logic              unmute_front,
    output logic              unmute_rear,
    output logic              clip_hi,
    output logic              fast_mute,
    output logic              amp_on,
    output logic              line_mode,
    output logic              read_done
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [RD_IDX_W-1:0] rd_idx;
    logic [7:0] rd_byte, wr_data;
    logic       wr_stb;
    logic [1:0] wr_idx;
    logic [6:0] ib1_q;
    logic [2:0] ib2_q;

    amp_i2c_sampler #(.SYNC(SYNC)) u_smp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det));

    amp_i2c_link #(.ADDR7(ADDR7)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_byte(rd_byte), .rd_idx(rd_idx),
        .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
        .sda_oe(sda_oe), .read_done(read_done));

    amp_i2c_status u_stat (
        .idx(rd_idx), .ch_flags(ch_flags), .thermal_warn(thermal_warn),
        .cycle_done(cycle_done), .offset_active(offset_active),
        .amp_on(amp_on), .diag_en(diag_en), .byte_o(rd_byte));

    // Instruction registers: first byte keeps bits 6..0, second keeps bits 5..3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ib1_q <= '0;
            ib2_q <= '0;
        end else if (wr_stb) begin
            if (wr_idx == 2'd0) ib1_q <= wr_data[6:0];
            if (wr_idx == 2'd1) ib2_q <= wr_data[5:3];
        end
    end

    assign {diag_en, offs_en, gain_front_lo, gain_rear_lo,
            unmute_front, unmute_rear, clip_hi} = ib1_q;
    assign {fast_mute, amp_on, line_mode} = ib2_q;

    // R5: controls hold unless a byte strobe arrived in the previous cycle.
    assert_ctl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> $stable({ib1_q, ib2_q}));
endmodule

// File: tb/sim_amp_ctl_i2c_slave.sv
module sim_amp_ctl_i2c_slave;
    localparam int CLK_NS = 10;
    localparam int Q      = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, read_done;
    logic [15:0] ch_flags = '0;
    logic thermal_warn = 1'b0, cycle_done = 1'b0, offset_active = 1'b0;
    logic diag_en, offs_en, gain_front_lo, gain_rear_lo, unmute_front,
          unmute_rear, clip_hi, fast_mute, amp_on, line_mode;
    wire  sda_bus = m_sda & ~sda_oe;

    int checks = 0, errors = 0, rd_cnt = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    amp_ctl_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .ch_flags(ch_flags), .thermal_warn(thermal_warn), .cycle_done(cycle_done),
        .offset_active(offset_active), .diag_en(diag_en), .offs_en(offs_en),
        .gain_front_lo(gain_front_lo), .gain_rear_lo(gain_rear_lo),
        .unmute_front(unmute_front), .unmute_rear(unmute_rear), .clip_hi(clip_hi),
        .fast_mute(fast_mute), .amp_on(amp_on), .line_mode(line_mode),
        .read_done(read_done));

    always @(posedge clk) if (read_done) rd_cnt <= rd_cnt + 1;

    function automatic logic [9:0] ctl();
        return {diag_en, offs_en, gain_front_lo, gain_rear_lo, unmute_front,
                unmute_rear, clip_hi, fast_mute, amp_on, line_mode};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask
    task automatic bus_start(); m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq(); endtask
    task automatic bus_stop(); m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq(); wq(); endtask
    task automatic put_bit(input logic b); m_sda = b; wq(); m_scl = 1; wq(); wq(); m_scl = 0; wq(); endtask
    task automatic get_bit(output logic b);
        m_sda = 1; wq(); m_scl = 1; wq(); b = sda_bus; wq(); m_scl = 0; wq();
    endtask
    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b); ack = ~b;
    endtask
    task automatic get_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(~give_ack);
    endtask
    task automatic write2(input logic [7:0] a, input logic [7:0] b);
        logic k;
        bus_start(); put_byte(8'hD8, k); put_byte(a, k); put_byte(b, k); bus_stop();
    endtask

    // {ib1, ib2, expected {diag,offs,gf,gr,uf,ur,clip,fast,on,line}}
    localparam logic [25:0] VEC [6] = '{
        {8'h7F, 8'h38, 10'b1111111111},
        {8'h00, 8'h00, 10'b0000000000},
        {8'h40, 8'h10, 10'b1000000010},
        {8'h15, 8'h20, 10'b0010101100},
        {8'hAA, 8'hC8, 10'b0101010001},
        {8'h80, 8'h07, 10'b0000000000}
    };

    initial begin
        logic k;
        logic [7:0] d;
        int rd0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        wq();
        chk("R10 reset controls", 16'(ctl()), 16'h0);
        chk("R10 reset sda", 16'(sda_oe), 16'h0);

        // R3 R4 table walk
        foreach (VEC[i]) begin
            write2(VEC[i][25:18], VEC[i][17:10]);
            chk("R3/R4 control vector", 16'(ctl()), 16'(VEC[i][9:0]));
        end

        // R1: address acknowledge, foreign address ignored
        write2(8'h7F, 8'h38);
        bus_start(); put_byte(8'hD0, k);
        chk("R1 foreign address nack", 16'(k), 16'h0);
        put_byte(8'h00, k); put_byte(8'h00, k); bus_stop();
        chk("R1 foreign write ignored", 16'(ctl()), 16'h3FF);
        bus_start(); put_byte(8'hD8, k);
        chk("R1 own address ack", 16'(k), 16'h1);
        // R5: third byte acknowledged and ignored
        put_byte(8'h00, k); put_byte(8'h00, k); put_byte(8'h7F, k);
        chk("R5 extra byte ack", 16'(k), 16'h1);
        put_byte(8'h38, k); bus_stop();
        chk("R5 extra bytes ignored", 16'(ctl()), 16'h0);
        chk("R9 no strobe on write", 16'(rd_cnt), 16'h0);

        // R2: START mid-byte restarts address phase
        bus_start(); put_byte(8'hD8, k);
        put_bit(1); put_bit(1); put_bit(1);
        bus_start(); put_byte(8'hD8, k); put_byte(8'h40, k); put_byte(8'h10, k); bus_stop();
        chk("R2 restart after partial byte", 16'(ctl()), 16'h202);

        // R6 R7 R8 R9: read
        ch_flags = 16'hA5C3; thermal_warn = 1; cycle_done = 0; offset_active = 1;
        rd0 = rd_cnt;
        bus_start(); put_byte(8'hD9, k);
        chk("R1 read address ack", 16'(k), 16'h1);
        get_byte(1, d); chk("R6 R7 byte1", 16'(d), 16'h0083);
        get_byte(1, d); chk("R6 R7 byte2", 16'(d), 16'h008C);
        get_byte(1, d); chk("R6 R7 byte3", 16'(d), 16'h00C5);
        get_byte(1, d); chk("R6 byte4", 16'(d), 16'h000A);
        get_byte(0, d); chk("R8 byte past end", 16'(d), 16'h0000);
        get_bit(k);
        chk("R8 released after nack", 16'(k), 16'h1);
        chk("R9 no strobe before stop", 16'(rd_cnt - rd0), 16'h0);
        bus_stop();
        chk("R9 one strobe at stop", 16'(rd_cnt - rd0), 16'h1);

        // R7: headers follow inputs and controls
        ch_flags = 16'h0000; thermal_warn = 0; cycle_done = 1; offset_active = 0;
        write2(8'h00, 8'h00);
        bus_start(); put_byte(8'hD9, k);
        get_byte(1, d); chk("R7 byte1 cycle done", 16'(d), 16'h0040);
        get_byte(1, d); chk("R7 byte2 header clear", 16'(d), 16'h0000);
        get_byte(0, d); chk("R7 byte3 echo clear", 16'(d), 16'h0000);
        bus_stop();
        chk("R9 second strobe", 16'(rd_cnt - rd0), 16'h2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule